// File: doc/BRIEF.md
# Index-Register Prefixed Instruction Executor

This block runs the second half of an 8-bit processor's indexed instruction page. It reads an in-order byte stream. A selector byte picks one of two 16-bit index registers, and both registers share a single opcode map. The opcode byte comes next, followed by up to two operand bytes, which are either a signed displacement or immediate data.

The block holds the architectural state these instructions touch:
- the two index registers;
- the seven byte registers;
- the stack pointer;
- the program counter.

It forms indexed and stack addresses and drives a byte-wide memory port. That port has a combinational read path and a write strobe that takes effect at the clock edge. Multi-byte memory operations take one cycle per byte.

Flag logic lives outside the block. For the 8-bit arithmetic and logic forms, the block presents the operation code and both operands to an external ALU and accepts its combinational result. Escape opcode 0xCB is passed to another handler through a one-cycle pulse. Any other unknown opcode raises a one-cycle invalid pulse and leaves all state unchanged.

Top module: `idx_prefix_exec`

## Requirements
- R1: When idle, byte 0xDD selects index register X and byte 0xFD selects index register Y for the next opcode. Any other byte seen while idle is consumed and discarded with no effect on state.
- R2: For opcodes 0x40–0x7F other than 0x76, bits 5:3 name the destination and bits 2:0 the source, with codes B=0, C=1, D=2, E=3, H=4, L=5, A=7. In a register-to-register move, codes 4 and 5 denote the high and low byte of the selected index register. `gpr_q` byte k holds the register with code k, and byte 6 always reads zero.
- R3: A form with code 6 reads or writes memory at the index register plus a sign-extended displacement byte, wrapping modulo 2^16. In such a form the other register code 4 or 5 means the real H or L.
- R4: Opcode 0x36 takes the displacement byte first and the data byte second, then writes the data byte to the indexed address.
- R5: For opcodes 0x80–0xBF whose source code is 4, 5 or 6, `alu_op` carries bits 5:3, `alu_a` carries A and `alu_b` carries the operand. A takes `alu_res` unless `alu_op` is 7, the compare operation, which leaves A unchanged.
- R6: 0x24/0x2C increment and 0x25/0x2D decrement the index high/low byte modulo 256. 0x34/0x35 read the indexed byte, then write the incremented/decremented value back to the same address.
- R7: 0x23/0x2B increment/decrement the whole index register. 0x09/0x19/0x29/0x39 add BC, DE, the index register itself or SP to it, modulo 2^16, with BC = {B,C} and DE = {D,E}.
- R8: 0x21 loads the index register from two immediate bytes. 0x22 stores it to a two-byte absolute address. 0x2A loads it from such an address. All 16-bit values are little-endian, low byte first and at the lower address.
- R9: 0xE1 pops the index register from SP and adds 2 to SP. 0xE5 subtracts 2 from SP and writes the low byte at the new SP and the high byte at SP+1. 0xE3 swaps the index register with the word at SP and leaves SP unchanged.
- R10: 0xE9 copies the index register into PC, and 0xF9 copies it into SP.
- R11: An opcode outside the map pulses `bad_op` for one cycle and changes no state. 0xCB pulses `cb_handoff` for one cycle and changes no state.
- R12: After reset every index, byte, SP and PC register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A stream byte is present |
| in_byte | input | 8 | Current stream byte |
| in_take | output | 1 | Stream byte consumed at this edge |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read in this cycle |
| mem_rdata | input | 8 | Combinational read data |
| mem_we | output | 1 | Memory write at this edge |
| mem_wdata | output | 8 | Write data |
| alu_go | output | 1 | ALU result consumed this cycle |
| alu_op | output | 3 | ALU operation code |
| alu_a | output | 8 | ALU first operand (A) |
| alu_b | output | 8 | ALU second operand |
| alu_res | input | 8 | ALU result |
| bad_op | output | 1 | Invalid opcode pulse |
| cb_handoff | output | 1 | Escape page handoff pulse |
| ix_q | output | 16 | Index register X |
| iy_q | output | 16 | Index register Y |
| sp_q | output | 16 | Stack pointer |
| pc_q | output | 16 | Program counter |
| gpr_q | output | 64 | Byte registers, byte k = register code k |

## Verification
A displacement of 0x80 from a small index value has to wrap below zero. An unsigned extension would put the access about 256 bytes too high instead. A push from SP = 1 must wrap to 0xFFFF. Opcodes 0x66, 0x6E, 0x74 and 0x75 are run against index halves that differ from H and L, so a decoder that maps halves inside memory forms would load or store the wrong byte. Opcode 0x6C and the compare operation are exercised directly, and an invalid or escape opcode is followed by a full state and memory comparison, so any stray write would show up.

// File: rtl/idx_prefix_exec.sv
module idx_prefix_exec #(
  parameter logic [7:0] SEL_X = 8'hDD,
  parameter logic [7:0] SEL_Y = 8'hFD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_take,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic        alu_go,
  output logic [2:0]  alu_op,
  output logic [7:0]  alu_a,
  output logic [7:0]  alu_b,
  input  logic [7:0]  alu_res,
  output logic        bad_op,
  output logic        cb_handoff,
  output logic [15:0] ix_q,
  output logic [15:0] iy_q,
  output logic [15:0] sp_q,
  output logic [15:0] pc_q,
  output logic [63:0] gpr_q
);
  typedef enum logic [2:0] {S_IDLE, S_OPC, S_DISP, S_IMM, S_RD, S_WR} st_t;
  st_t st;
  logic        sel, cnt;
  logic [7:0]  op;
  logic [15:0] base, tmp, sp, pc;
  logic [15:0] ixy [2];
  logic [7:0]  gr [8];

  wire [7:0]  opc = (st == S_OPC) ? in_byte : op;
  wire [2:0]  fx = opc[5:3];
  wire [2:0]  fz = opc[2:0];
  wire [15:0] idx = ixy[sel];

  wire hl_d = (fx == 3'd4) || (fx == 3'd5);
  wire hl_s = (fz == 3'd4) || (fz == 3'd5);
  wire is_ld = (opc[7:6] == 2'b01) && (opc != 8'h76);
  wire is_al = (opc[7:6] == 2'b10);
  wire ld_mr = is_ld && fz == 3'd6;
  wire ld_rm = is_ld && fx == 3'd6;
  wire ld_rr = is_ld && fx != 3'd6 && fz != 3'd6 && (hl_d || hl_s);
  wire alu_m = is_al && fz == 3'd6;
  wire alu_h = is_al && hl_s;
  wire idc_h = opc[7:6] == 2'b00 && fz[2:1] == 2'b10 && hl_d;
  wire idc_m = opc[7:6] == 2'b00 && fz[2:1] == 2'b10 && fx == 3'd6;
  wire ld_hn = opc == 8'h26 || opc == 8'h2E;
  wire ld_mn = opc == 8'h36;
  wire add16 = opc[7:6] == 2'b00 && opc[3:0] == 4'h9;
  wire wd_op = opc == 8'h21 || opc == 8'h22 || opc == 8'h2A;
  wire need_d = ld_mr || ld_rm || alu_m || idc_m || ld_mn;
  wire misc = opc == 8'h23 || opc == 8'h2B || opc == 8'hE1 || opc == 8'hE3 ||
              opc == 8'hE5 || opc == 8'hE9 || opc == 8'hF9;
  wire ok_op = need_d || ld_rr || alu_h || idc_h || ld_hn || add16 || wd_op || misc;
  wire rd_two = opc == 8'h2A || opc == 8'hE1 || opc == 8'hE3;
  wire wr_two = opc == 8'h22 || opc == 8'hE3 || opc == 8'hE5;

  wire [7:0] step   = opc[0] ? 8'hFF : 8'h01;
  wire [7:0] s_real = gr[fz];
  wire [7:0] s_half = (fz == 3'd4) ? idx[15:8] : (fz == 3'd5) ? idx[7:0] : gr[fz];
  wire [7:0] d_half = (fx == 3'd4) ? idx[15:8] : (fx == 3'd5) ? idx[7:0] : gr[fx];
  logic [15:0] pair;
  always_comb
    case (opc[5:4])
      2'd0: pair = {gr[0], gr[1]};
      2'd1: pair = {gr[2], gr[3]};
      2'd2: pair = idx;
      default: pair = sp;
    endcase

  logic       r8_we, r8_hl, ix_we, sp_we, pc_we;
  logic [2:0] r8_dst;
  logic [7:0] r8_val;
  logic [15:0] ix_val, sp_val;

  assign in_take    = in_valid && (st == S_IDLE || st == S_OPC || st == S_DISP || st == S_IMM);
  assign bad_op     = st == S_OPC && in_valid && !ok_op && opc != 8'hCB;
  assign cb_handoff = st == S_OPC && in_valid && opc == 8'hCB;
  assign mem_addr   = base + {15'd0, cnt};
  assign alu_op     = fx;
  assign alu_a      = gr[7];

  always_comb begin
    r8_we = 1'b0; r8_hl = 1'b0; r8_dst = fx; r8_val = 8'h00;
    ix_we = 1'b0; ix_val = idx; sp_we = 1'b0; sp_val = sp; pc_we = 1'b0;
    alu_go = 1'b0; alu_b = 8'h00; mem_rd = 1'b0; mem_we = 1'b0; mem_wdata = 8'h00;
    case (st)
      S_OPC: if (in_valid) begin
        if (ld_rr) begin r8_we = 1'b1; r8_hl = 1'b1; r8_val = s_half; end
        if (alu_h) begin alu_go = 1'b1; alu_b = s_half; end
        if (idc_h) begin r8_we = 1'b1; r8_hl = 1'b1; r8_val = d_half + step; end
        if (add16) begin ix_we = 1'b1; ix_val = idx + pair; end
        if (opc == 8'h23) begin ix_we = 1'b1; ix_val = idx + 16'd1; end
        if (opc == 8'h2B) begin ix_we = 1'b1; ix_val = idx - 16'd1; end
        if (opc == 8'hE9) pc_we = 1'b1;
        if (opc == 8'hF9) begin sp_we = 1'b1; sp_val = idx; end
      end
      S_IMM: if (in_valid) begin
        if (ld_hn) begin r8_we = 1'b1; r8_hl = 1'b1; r8_val = in_byte; end
        if (opc == 8'h21 && cnt) begin ix_we = 1'b1; ix_val = {in_byte, tmp[7:0]}; end
      end
      S_RD: begin
        mem_rd = 1'b1;
        if (ld_mr) begin r8_we = 1'b1; r8_val = mem_rdata; end
        if (alu_m) begin alu_go = 1'b1; alu_b = mem_rdata; end
        if ((opc == 8'h2A || opc == 8'hE1) && cnt) begin ix_we = 1'b1; ix_val = {mem_rdata, tmp[7:0]}; end
        if (opc == 8'hE1 && cnt) begin sp_we = 1'b1; sp_val = sp + 16'd2; end
      end
      S_WR: begin
        mem_we = 1'b1;
        if (ld_rm)      mem_wdata = s_real;
        else if (ld_mn) mem_wdata = tmp[7:0];
        else if (idc_m) mem_wdata = tmp[7:0] + step;
        else            mem_wdata = cnt ? idx[15:8] : idx[7:0];
        if (opc == 8'hE3 && cnt) begin ix_we = 1'b1; ix_val = tmp; end
        if (opc == 8'hE5 && cnt) begin sp_we = 1'b1; sp_val = base; end
      end
      default: ;
    endcase
    if (alu_go && fx != 3'd7) begin r8_we = 1'b1; r8_hl = 1'b0; r8_dst = 3'd7; r8_val = alu_res; end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sel <= 1'b0; cnt <= 1'b0; op <= 8'h00;
      base <= '0; tmp <= '0; sp <= '0; pc <= '0;
      ixy[0] <= '0; ixy[1] <= '0;
      for (int k = 0; k < 8; k++) gr[k] <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid && (in_byte == SEL_X || in_byte == SEL_Y)) begin
          sel <= in_byte == SEL_Y; st <= S_OPC;
        end
        S_OPC: if (in_valid) begin
          op <= in_byte; cnt <= 1'b0; st <= S_IDLE;
          if (ok_op) begin
            if (need_d) st <= S_DISP;
            else if (ld_hn || wd_op) st <= S_IMM;
            else if (opc == 8'hE1 || opc == 8'hE3) begin base <= sp; st <= S_RD; end
            else if (opc == 8'hE5) begin base <= sp - 16'd2; st <= S_WR; end
          end
        end
        S_DISP: if (in_valid) begin
          base <= idx + {{8{in_byte[7]}}, in_byte};
          st <= ld_mn ? S_IMM : ld_rm ? S_WR : S_RD;
        end
        S_IMM: if (in_valid) begin
          tmp[7:0] <= in_byte;
          if (wd_op && !cnt) cnt <= 1'b1;
          else begin
            cnt <= 1'b0; st <= S_IDLE;
            if (ld_mn) st <= S_WR;
            if (opc == 8'h22) begin base <= {in_byte, tmp[7:0]}; st <= S_WR; end
            if (opc == 8'h2A) begin base <= {in_byte, tmp[7:0]}; st <= S_RD; end
          end
        end
        S_RD: begin
          if (cnt) tmp[15:8] <= mem_rdata; else tmp[7:0] <= mem_rdata;
          if (rd_two && !cnt) cnt <= 1'b1;
          else begin cnt <= 1'b0; st <= (opc == 8'hE3 || idc_m) ? S_WR : S_IDLE; end
        end
        S_WR: begin
          if (wr_two && !cnt) cnt <= 1'b1;
          else begin cnt <= 1'b0; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
      if (r8_we) begin
        if (r8_hl && r8_dst == 3'd4)      ixy[sel][15:8] <= r8_val;
        else if (r8_hl && r8_dst == 3'd5) ixy[sel][7:0]  <= r8_val;
        else                              gr[r8_dst]     <= r8_val;
      end
      if (ix_we) ixy[sel] <= ix_val;
      if (sp_we) sp <= sp_val;
      if (pc_we) pc <= idx;
    end

  assign ix_q = ixy[0];
  assign iy_q = ixy[1];
  assign sp_q = sp;
  assign pc_q = pc;
  for (genvar k = 0; k < 8; k++) begin : g_pack
    assign gpr_q[8*k +: 8] = gr[k];
  end

  // R11: rejected and escaped opcodes leave every register untouched
  p_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_op || cb_handoff) |=> ($stable(ix_q) && $stable(iy_q) && $stable(sp_q) &&
                                $stable(pc_q) && $stable(gpr_q)));
  // R6: the write-back of a read-modify-write hits the byte just read
  p_rmw_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && idc_m) |-> (mem_addr == $past(mem_addr) && $past(mem_rd)));
  // R10: PC only ever takes the selected index value
  p_pc_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> (pc_q == $past(sel ? iy_q : ix_q)));
  // R9: SP moves by exactly two or is loaded from the index register
  p_sp_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> (sp_q == $past(sp_q) + 16'd2 || sp_q == $past(sp_q) - 16'd2 ||
                        sp_q == $past(sel ? iy_q : ix_q)));
  // R5: compare leaves A unchanged
  p_cmp_keeps_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_go && alu_op == 3'd7) |=> $stable(gpr_q[63:56]));
endmodule

// File: tb/idx_prefix_exec_tb_top.sv
`timescale 1ns/1ps
module idx_prefix_exec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] sbuf [0:4095];
  int wr_p = 0;
  int rd_p;
  logic        in_valid, in_take, mem_rd, mem_we, alu_go, bad_op, cb_handoff;
  logic [7:0]  in_byte, mem_rdata, mem_wdata, alu_a, alu_b, alu_res;
  logic [2:0]  alu_op;
  logic [15:0] mem_addr, ix_q, iy_q, sp_q, pc_q, last_wa;
  logic [63:0] gpr_q;
  logic [7:0]  mem [0:1023];

  function automatic logic [7:0] alu_fn(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
    return a + (b ^ {5'd0, o});
  endfunction

  assign in_valid  = rd_p != wr_p;
  assign in_byte   = sbuf[rd_p[11:0]];
  assign mem_rdata = mem[mem_addr[9:0]];
  assign alu_res   = alu_fn(alu_op, alu_a, alu_b);

  int bad_cnt, cb_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin rd_p <= 0; bad_cnt <= 0; cb_cnt <= 0; last_wa <= '0; end
    else begin
      if (in_take) rd_p <= rd_p + 1;
      if (mem_we) begin mem[mem_addr[9:0]] <= mem_wdata; last_wa <= mem_addr; end
      if (bad_op) bad_cnt <= bad_cnt + 1;
      if (cb_handoff) cb_cnt <= cb_cnt + 1;
    end
  end

  idx_prefix_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_take(in_take),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .alu_go(alu_go), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .alu_res(alu_res), .bad_op(bad_op), .cb_handoff(cb_handoff), .ix_q(ix_q), .iy_q(iy_q),
    .sp_q(sp_q), .pc_q(pc_q), .gpr_q(gpr_q));

  int total = 0, fails = 0, exp_bad = 0, exp_cb = 0;
  bit ended = 1'b0;
  logic [15:0] m_idx [2];
  logic [7:0]  m_gr [8];
  logic [15:0] m_sp, m_pc;
  logic [7:0]  m_mem [0:1023];

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  function automatic int xlen(input logic [7:0] o);
    logic [2:0] y = o[5:3], z = o[2:0];
    bit hy = (y == 3'd4 || y == 3'd5), hz = (z == 3'd4 || z == 3'd5);
    if (o[7:6] == 2'b01 && o != 8'h76) return (z == 3'd6 || y == 3'd6) ? 1 : ((hy || hz) ? 0 : -1);
    if (o[7:6] == 2'b10) return (z == 3'd6) ? 1 : (hz ? 0 : -1);
    case (o)
      8'h24, 8'h25, 8'h2C, 8'h2D, 8'h09, 8'h19, 8'h29, 8'h39,
      8'h23, 8'h2B, 8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9: return 0;
      8'h34, 8'h35, 8'h26, 8'h2E: return 1;
      8'h36, 8'h21, 8'h22, 8'h2A: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] get8(input bit s, input logic [2:0] k);
    if (k == 3'd4) return m_idx[s][15:8];
    if (k == 3'd5) return m_idx[s][7:0];
    return m_gr[k];
  endfunction

  task automatic set8(input bit s, input logic [2:0] k, input logic [7:0] v);
    if (k == 3'd4) m_idx[s][15:8] = v;
    else if (k == 3'd5) m_idx[s][7:0] = v;
    else m_gr[k] = v;
  endtask

  task automatic model(input bit s, input logic [7:0] o, input logic [7:0] x1, input logic [7:0] x2);
    logic [2:0]  y = o[5:3], z = o[2:0];
    logic [15:0] ix = m_idx[s];
    logic [15:0] ea = ix + {{8{x1[7]}}, x1};
    logic [15:0] ab = {x2, x1};
    logic [15:0] w;
    logic [7:0]  v;
    if (o[7:6] == 2'b01) begin
      if (z == 3'd6) m_gr[y] = m_mem[ea[9:0]];
      else if (y == 3'd6) m_mem[ea[9:0]] = m_gr[z];
      else set8(s, y, get8(s, z));
    end else if (o[7:6] == 2'b10) begin
      v = (z == 3'd6) ? m_mem[ea[9:0]] : get8(s, z);
      v = alu_fn(y, m_gr[7], v);
      if (y != 3'd7) m_gr[7] = v;
    end else
      case (o)
        8'h24, 8'h2C: set8(s, y, get8(s, y) + 8'd1);
        8'h25, 8'h2D: set8(s, y, get8(s, y) - 8'd1);
        8'h34: m_mem[ea[9:0]] = m_mem[ea[9:0]] + 8'd1;
        8'h35: m_mem[ea[9:0]] = m_mem[ea[9:0]] - 8'd1;
        8'h26, 8'h2E: set8(s, y, x1);
        8'h36: m_mem[ea[9:0]] = x2;
        8'h09: m_idx[s] = ix + {m_gr[0], m_gr[1]};
        8'h19: m_idx[s] = ix + {m_gr[2], m_gr[3]};
        8'h29: m_idx[s] = ix + ix;
        8'h39: m_idx[s] = ix + m_sp;
        8'h21: m_idx[s] = ab;
        8'h22: begin w = ab + 16'd1; m_mem[ab[9:0]] = ix[7:0]; m_mem[w[9:0]] = ix[15:8]; end
        8'h2A: begin w = ab + 16'd1; m_idx[s] = {m_mem[w[9:0]], m_mem[ab[9:0]]}; end
        8'h23: m_idx[s] = ix + 16'd1;
        8'h2B: m_idx[s] = ix - 16'd1;
        8'hE1: begin w = m_sp + 16'd1; m_idx[s] = {m_mem[w[9:0]], m_mem[m_sp[9:0]]}; m_sp = m_sp + 16'd2; end
        8'hE3: begin
          w = m_sp + 16'd1;
          m_idx[s] = {m_mem[w[9:0]], m_mem[m_sp[9:0]]};
          m_mem[m_sp[9:0]] = ix[7:0]; m_mem[w[9:0]] = ix[15:8];
        end
        8'hE5: begin m_sp = m_sp - 16'd2; w = m_sp + 16'd1; m_mem[m_sp[9:0]] = ix[7:0]; m_mem[w[9:0]] = ix[15:8]; end
        8'hE9: m_pc = ix;
        8'hF9: m_sp = ix;
        default: ;
      endcase
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [63:0] eg;
    int bad_at = -1;
    for (int k = 0; k < 8; k++) eg[8*k +: 8] = m_gr[k];
    chk(gpr_q === eg, tag, "gpr", gpr_q, eg);
    chk({ix_q, iy_q, sp_q, pc_q} === {m_idx[0], m_idx[1], m_sp, m_pc}, tag, "ix/iy/sp/pc",
        {ix_q, iy_q, sp_q, pc_q}, {m_idx[0], m_idx[1], m_sp, m_pc});
    for (int k = 1023; k >= 0; k--) if (mem[k] !== m_mem[k]) bad_at = k;
    if (bad_at < 0) chk(1'b1, tag, "memory", 64'd0, 64'd0);
    else chk(1'b0, tag, "memory byte", {48'd0, mem[bad_at]}, {48'd0, m_mem[bad_at]});
    chk(bad_cnt == exp_bad && cb_cnt == exp_cb, tag, "bad/cb pulses",
        {bad_cnt[31:0], cb_cnt[31:0]}, {exp_bad[31:0], exp_cb[31:0]});
  endtask

  task automatic push(input logic [7:0] b);
    sbuf[wr_p[11:0]] = b;
    wr_p++;
  endtask

  task automatic drain();
    @(negedge clk);
    while (rd_p != wr_p) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic run(input string tag, input bit s, input logic [7:0] o, input logic [7:0] x1, input logic [7:0] x2);
    int n = xlen(o);
    push(s ? 8'hFD : 8'hDD);
    push(o);
    if (n > 0) push(x1);
    if (n > 1) push(x2);
    if (o == 8'hCB) exp_cb++;
    else if (n < 0) exp_bad++;
    else model(s, o, x1, x2);
    drain();
    chk_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 1024; k++) begin mem[k] = 8'($urandom); m_mem[k] = mem[k]; end
    for (int k = 0; k < 8; k++) m_gr[k] = 8'h00;
    m_idx[0] = '0; m_idx[1] = '0; m_sp = '0; m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R12 reset");

    push(8'h3C); push(8'h21); drain();
    chk_all("R1 stray bytes ignored");
    run("R1 select X", 1'b0, 8'h21, 8'h05, 8'h00);
    run("R1 select Y", 1'b1, 8'h21, 8'h34, 8'h12);

    run("R3 load B", 1'b0, 8'h46, 8'h10, 8'h00);
    run("R3 load H real", 1'b1, 8'h66, 8'h02, 8'h00);
    run("R3 load L real", 1'b1, 8'h6E, 8'hFE, 8'h00);
    run("R3 negative wrap store", 1'b0, 8'h70, 8'h80, 8'h00);
    chk(last_wa == 16'hFF85, "R3", "wrapped address", {48'd0, last_wa}, 64'hFF85);
    run("R3 positive store", 1'b0, 8'h77, 8'h7F, 8'h00);
    chk(last_wa == 16'h0084, "R3", "positive address", {48'd0, last_wa}, 64'h0084);
    run("R3 store real H", 1'b1, 8'h74, 8'h01, 8'h00);
    run("R3 store real L", 1'b1, 8'h75, 8'h03, 8'h00);
    run("R4 store immediate", 1'b0, 8'h36, 8'hFF, 8'hA5);
    chk(last_wa == 16'h0004, "R4", "address", {48'd0, last_wa}, 64'h0004);

    run("R2 low from high", 1'b1, 8'h6C, 8'h00, 8'h00);
    run("R2 E from high", 1'b1, 8'h5C, 8'h00, 8'h00);
    run("R2 high from A", 1'b0, 8'h67, 8'h00, 8'h00);
    run("R5 compare keeps A", 1'b1, 8'hBE, 8'h02, 8'h00);
    run("R5 add low half", 1'b1, 8'h85, 8'h00, 8'h00);
    run("R6 inc memory", 1'b0, 8'h34, 8'h20, 8'h00);
    run("R6 dec memory", 1'b1, 8'h35, 8'h80, 8'h00);
    run("R6 dec high half", 1'b0, 8'h25, 8'h00, 8'h00);
    run("R7 add self", 1'b1, 8'h29, 8'h00, 8'h00);
    run("R7 dec", 1'b0, 8'h2B, 8'h00, 8'h00);

    run("R8 set X", 1'b0, 8'h21, 8'h01, 8'h00);
    run("R10 SP from X", 1'b0, 8'hF9, 8'h00, 8'h00);
    run("R9 push wraps", 1'b0, 8'hE5, 8'h00, 8'h00);
    chk(sp_q == 16'hFFFF && last_wa == 16'h0000, "R9", "push sp/addr",
        {32'd0, sp_q, last_wa}, 64'h0000_0000_FFFF_0000);
    run("R9 exchange", 1'b1, 8'hE3, 8'h00, 8'h00);
    run("R9 pop", 1'b1, 8'hE1, 8'h00, 8'h00);
    run("R8 store abs", 1'b1, 8'h22, 8'hFF, 8'h01);
    run("R8 load abs", 1'b0, 8'h2A, 8'hFF, 8'h01);
    run("R10 jump", 1'b1, 8'hE9, 8'h00, 8'h00);

    run("R11 invalid 00", 1'b0, 8'h00, 8'h00, 8'h00);
    run("R11 invalid 76", 1'b1, 8'h76, 8'h00, 8'h00);
    run("R11 invalid 40", 1'b0, 8'h40, 8'h00, 8'h00);
    run("R11 escape CB", 1'b1, 8'hCB, 8'h00, 8'h00);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] o;
      do o = 8'($urandom); while (xlen(o) < 0 && (i % 16) != 0);
      run("R2-R11 random", 1'($urandom), o, 8'($urandom), 8'($urandom));
    end
    summary();
  end
endmodule